// File: doc/BRIEF.md
# Vector Register File With Upper-Half Access

This block holds thirty-two vector registers, each `VLMAX` bits wide (128 by default, any multiple of 128). A write port takes a register index, an access size, a half selector and data. A low-half write zero-extends the data. An upper-half write puts 64 bits into bits 127:64 and keeps the low 64 bits. How far a write clears or keeps the bits above its data depends on an active vector length and a policy bit. The active length counts 128-bit granules and applies only when the extended-length mode is on. When the policy bit is set, a write clears the whole physical register.

Reads take an index, a size and a half selector. The block returns the low bits of the chosen width, or the upper 64-bit half of the low 128 bits, in a registered response. Both ports are valid/ready. The write port is always ready and commits on the clock edge that accepts it. The read port holds one response and keeps it until the consumer takes it. A new read request is accepted only when the response slot is empty or is being drained in the same cycle.

Top module: `vrf_top`

## Requirements
- R1: After reset every register reads as zero, the response slot is empty and `rd_req_ready` is high.
- R2: Size codes: 0=8, 1=16, 2=32, 3=64, 4=128 bits; 5, 6 and 7 mean the whole register. A low-half write (`wr_part`=0) stores the low size bits of `wr_data` and zeroes the bits from there up to the active length.
- R3: With `clr_all`=0, a write leaves every bit at or above the active length unchanged.
- R4: With `clr_all`=1, a low-half write clears every bit above its size across the whole register.
- R5: The active length is 128 bits when `ext_en`=0. When `ext_en`=1 it is `act_len`×128 bits, where 0 counts as 1 and values above `VLMAX`/128 count as `VLMAX`/128.
- R6: An upper-half write (`wr_part`=1, size ignored) sets bits 127:64 to `wr_data[63:0]` and keeps bits 63:0. It clears bits from 128 up to the active length, or all bits above 127 when `clr_all`=1. Other bits keep their value.
- R7: A low-half read returns the low size bits of the register, with zeros above them in `rd_rsp_data`.
- R8: An upper-half read returns register bits 127:64 in `rd_rsp_data[63:0]`, with all higher bits zero.
- R9: A read accepted on the same edge as a write to the same register returns the value from before the write.
- R10: `rd_req_ready` equals `!rd_rsp_valid || rd_rsp_ready`. While `rd_rsp_valid` is high and `rd_rsp_ready` is low, the response stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Extended-length mode enable |
| act_len | input | LENW | Active length in 128-bit granules |
| clr_all | input | 1 | Policy: clear whole register above written data |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_idx | input | 5 | Write register index |
| wr_size | input | 3 | Write size code |
| wr_part | input | 1 | Write half selector (1 = bits 127:64) |
| wr_data | input | VLMAX | Write data |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted |
| rd_idx | input | 5 | Read register index |
| rd_size | input | 3 | Read size code |
| rd_part | input | 1 | Read half selector |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_ready | input | 1 | Read response taken |
| rd_rsp_data | output | VLMAX | Read response data |

## Verification
The bench runs with a 256-bit register, so the granule above the active length can be seen. It fills that granule with a full-width write at maximum length, then writes again with a shorter length. A design that ignored the length or the policy bit would then clear or keep the wrong upper bits. Upper-half writes are checked for losing bits 63:0 or for leaving stale data between 128 and the active length. The `act_len` values 0 and past the maximum are exercised; a missing clamp would write zero or too many granules. A read and a write to the same register on the same edge must return the old value. Long stalls on `rd_rsp_ready` would expose a response that changes or is dropped while held.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int GRAN = 128;
  localparam int HALF = 64;
  localparam int NREG = 32;
  localparam int IDXW = 5;

  typedef logic [2:0] vsize_t;

  localparam vsize_t SZ_B8   = 3'd0;
  localparam vsize_t SZ_B16  = 3'd1;
  localparam vsize_t SZ_B32  = 3'd2;
  localparam vsize_t SZ_B64  = 3'd3;
  localparam vsize_t SZ_B128 = 3'd4;
  localparam vsize_t SZ_FULL = 3'd5;

  function automatic logic size_is_full(input vsize_t sz);
    return sz >= SZ_FULL;
  endfunction

  function automatic logic [GRAN-1:0] low_mask(input vsize_t sz);
    logic [GRAN-1:0] m;
    case (sz)
      SZ_B8:   m = {{(GRAN-8){1'b0}},  {8{1'b1}}};
      SZ_B16:  m = {{(GRAN-16){1'b0}}, {16{1'b1}}};
      SZ_B32:  m = {{(GRAN-32){1'b0}}, {32{1'b1}}};
      SZ_B64:  m = {{(GRAN-64){1'b0}}, {64{1'b1}}};
      default: m = {GRAN{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vrf_len_sel.sv
module vrf_len_sel #(
  parameter int NG   = 1,
  parameter int LENW = 1
) (
  input  logic            ext_en,
  input  logic [LENW-1:0] act_len,
  output logic [NG-1:0]   live
);
  logic [31:0] len_ext;
  logic [31:0] lg;

  assign len_ext = 32'(act_len);

  always_comb begin
    if (!ext_en || len_ext == 32'd0) lg = 32'd1;
    else if (len_ext > 32'(NG))      lg = 32'(NG);
    else                             lg = len_ext;
  end

  for (genvar g = 0; g < NG; g++) begin : g_live
    assign live[g] = 32'(g) < lg;
  end
endmodule

// File: rtl/vrf_wr_merge.sv
module vrf_wr_merge
  import vrf_pkg::*;
#(
  parameter int VLMAX = 128,
  parameter int NG    = VLMAX / GRAN
) (
  input  logic [VLMAX-1:0] old_v,
  input  logic [VLMAX-1:0] wr_data,
  input  vsize_t           sz,
  input  logic             part,
  input  logic             clr_all,
  input  logic [NG-1:0]    live,
  output logic [VLMAX-1:0] new_v
);
  logic            full;
  logic [GRAN-1:0] g0_low;

  assign full   = size_is_full(sz);
  assign g0_low = full ? wr_data[GRAN-1:0] : (wr_data[GRAN-1:0] & low_mask(sz));
  assign new_v[GRAN-1:0] = part ? {wr_data[HALF-1:0], old_v[HALF-1:0]} : g0_low;

  for (genvar g = 1; g < NG; g++) begin : g_hi
    logic [GRAN-1:0] src;
    assign src = (!part && full) ? wr_data[g*GRAN +: GRAN] : '0;
    assign new_v[g*GRAN +: GRAN] = (live[g] || clr_all) ? src : old_v[g*GRAN +: GRAN];
  end
endmodule

// File: rtl/vrf_rd_slice.sv
module vrf_rd_slice
  import vrf_pkg::*;
#(
  parameter int VLMAX = 128
) (
  input  logic [VLMAX-1:0] v,
  input  vsize_t           sz,
  input  logic             part,
  output logic [VLMAX-1:0] out
);
  always_comb begin
    out = '0;
    if (part)                   out[HALF-1:0] = v[GRAN-1:HALF];
    else if (size_is_full(sz))  out = v;
    else                        out[GRAN-1:0] = v[GRAN-1:0] & low_mask(sz);
  end
endmodule

// File: rtl/vrf_rsp_buf.sv
module vrf_rsp_buf #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_data <= req_data;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/vrf_top.sv
module vrf_top
  import vrf_pkg::*;
#(
  parameter int VLMAX = 128,
  parameter int NG    = VLMAX / GRAN,
  parameter int LENW  = $clog2(NG) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic [LENW-1:0]  act_len,
  input  logic             clr_all,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [4:0]       wr_idx,
  input  logic [2:0]       wr_size,
  input  logic             wr_part,
  input  logic [VLMAX-1:0] wr_data,
  input  logic             rd_req_valid,
  output logic             rd_req_ready,
  input  logic [4:0]       rd_idx,
  input  logic [2:0]       rd_size,
  input  logic             rd_part,
  output logic             rd_rsp_valid,
  input  logic             rd_rsp_ready,
  output logic [VLMAX-1:0] rd_rsp_data
);
  logic [VLMAX-1:0] mem [NREG];
  logic [NG-1:0]    live;
  logic [VLMAX-1:0] merged;
  logic [VLMAX-1:0] rd_sel;

  assign wr_ready = 1'b1;

  vrf_len_sel #(.NG(NG), .LENW(LENW)) i_len (
    .ext_en(ext_en), .act_len(act_len), .live(live));

  vrf_wr_merge #(.VLMAX(VLMAX), .NG(NG)) i_merge (
    .old_v(mem[wr_idx]), .wr_data(wr_data), .sz(wr_size), .part(wr_part),
    .clr_all(clr_all), .live(live), .new_v(merged));

  vrf_rd_slice #(.VLMAX(VLMAX)) i_slice (
    .v(mem[rd_idx]), .sz(rd_size), .part(rd_part), .out(rd_sel));

  vrf_rsp_buf #(.W(VLMAX)) i_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .req_data(rd_sel), .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready),
    .rsp_data(rd_rsp_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_valid) begin
      mem[wr_idx] <= merged;
    end
  end

  assert_clear_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_part && clr_all && wr_size <= SZ_B64
    |=> mem[$past(wr_idx)][VLMAX-1:HALF] == '0);

  assert_upper_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_part
    |=> mem[$past(wr_idx)][GRAN-1:HALF] == $past(wr_data[HALF-1:0]));

  assert_upper_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready && rd_part
    |=> rd_rsp_valid && rd_rsp_data[VLMAX-1:HALF] == '0);
endmodule

// File: tb/test_vrf_top.sv
module test_vrf_top;
  localparam int VW = 256;
  localparam int NG = VW / 128;
  localparam int LW = $clog2(NG) + 1;

  logic clk = 0, rst_n = 0;
  logic ext = 0, clr = 0, wv = 0, rqv = 0, rrdy = 1;
  logic [LW-1:0] len = '0;
  logic [4:0] widx = 0, ridx = 0;
  logic [2:0] wsz = 0, rsz = 0;
  logic wpt = 0, rpt = 0;
  logic [VW-1:0] wdat = '0;
  logic wr_ready, rd_req_ready, rd_rsp_valid;
  logic [VW-1:0] rd_rsp_data;

  int total = 0, bad = 0, cyc = 0;
  logic [VW-1:0] m_mem [32];
  logic ev = 0;
  logic [VW-1:0] ed = '0;
  string etag = "R1";
  string rtag = "R7";

  always #5 clk = ~clk;

  vrf_top #(.VLMAX(VW)) i_vrf_top (
    .clk(clk), .rst_n(rst_n), .ext_en(ext), .act_len(len), .clr_all(clr),
    .wr_valid(wv), .wr_ready(wr_ready), .wr_idx(widx), .wr_size(wsz),
    .wr_part(wpt), .wr_data(wdat), .rd_req_valid(rqv), .rd_req_ready(rd_req_ready),
    .rd_idx(ridx), .rd_size(rsz), .rd_part(rpt), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rrdy), .rd_rsp_data(rd_rsp_data));

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] sz);
    return (sz >= 3'd5) ? VW : (8 << sz);
  endfunction

  function automatic logic [VW-1:0] m_read(input logic [VW-1:0] v, input logic [2:0] sz, input logic part);
    logic [VW-1:0] r = '0;
    int w = width_of(sz);
    for (int b = 0; b < VW; b++) begin
      if (part) r[b] = (b < 64) ? v[b + 64] : 1'b0;
      else      r[b] = (b < w) ? v[b] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] m_write(input logic [VW-1:0] old, input logic [VW-1:0] d,
      input logic [2:0] sz, input logic part, input logic c, input logic e, input int ln);
    logic [VW-1:0] r;
    int g = (!e || ln == 0) ? 1 : (ln > NG ? NG : ln);
    int lbits = g * 128;
    int w = width_of(sz);
    for (int b = 0; b < VW; b++) begin
      if (part) begin
        if (b < 64)                  r[b] = old[b];
        else if (b < 128)            r[b] = d[b - 64];
        else if (b < lbits || c)     r[b] = 1'b0;
        else                         r[b] = old[b];
      end else begin
        if (b < lbits || c)          r[b] = (b < w) ? d[b] : 1'b0;
        else                         r[b] = old[b];
      end
    end
    return r;
  endfunction

  task automatic step();
    #1;
    chk(rd_req_ready === (!ev || rrdy), "R10 req_ready", VW'(rd_req_ready), VW'(!ev || rrdy));
    chk(wr_ready === 1'b1, "R10 wr_ready", VW'(wr_ready), VW'(1));
    @(posedge clk);
    if (!ev || rrdy) begin
      ev = rqv;
      if (rqv) begin
        ed = m_read(m_mem[ridx], rsz, rpt);
        etag = rtag;
      end
    end
    if (wv) m_mem[widx] = m_write(m_mem[widx], wdat, wsz, wpt, clr, ext, int'(len));
    @(negedge clk);
    chk(rd_rsp_valid === ev, "R10 rsp_valid", VW'(rd_rsp_valid), VW'(ev));
    if (ev) chk(rd_rsp_data === ed, etag, rd_rsp_data, ed);
  endtask

  task automatic do_wr(input int i, input logic [2:0] s, input logic p, input logic [VW-1:0] d);
    wv = 1; widx = 5'(i); wsz = s; wpt = p; wdat = d; rqv = 0;
    step();
    wv = 0;
  endtask

  task automatic do_rd(input int i, input logic [2:0] s, input logic p, input string tag);
    rqv = 1; ridx = 5'(i); rsz = s; rpt = p; rrdy = 1; rtag = tag;
    step();
    rqv = 0;
  endtask

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] r;
    for (int k = 0; k < VW / 32; k++) r[k*32 +: 32] = 32'h9E37_79B9 * (seed + k + 1) ^ 32'hC3A5_5A3C;
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rd_rsp_valid === 1'b0, "R1 rsp empty", VW'(rd_rsp_valid), '0);
    chk(rd_req_ready === 1'b1, "R1 req_ready", VW'(rd_req_ready), VW'(1));
    for (int i = 0; i < 32; i++) do_rd(i, 3'd5, 1'b0, "R1 reset zero");

    // R2 / R5: full write at max length, then a byte write zeroes up to length
    ext = 1; len = 2; clr = 0;
    do_wr(3, 3'd5, 0, pat(1)); do_rd(3, 3'd5, 0, "R5 full length");
    do_wr(3, 3'd0, 0, pat(2)); do_rd(3, 3'd5, 0, "R2 byte zext");
    do_wr(9, 3'd7, 0, pat(3)); do_rd(9, 3'd7, 0, "R2 size code 7");
    // R3: shorter length keeps upper granule
    do_wr(4, 3'd5, 0, pat(4));
    len = 1; do_wr(4, 3'd1, 0, pat(5)); do_rd(4, 3'd5, 0, "R3 keep above length");
    // R4: policy clears everything
    clr = 1; do_wr(4, 3'd2, 0, pat(6)); do_rd(4, 3'd5, 0, "R4 clear all");
    clr = 0;
    // R5: ext off, length zero, length over max
    len = 2; do_wr(6, 3'd5, 0, pat(7));
    ext = 0; do_wr(6, 3'd3, 0, pat(8)); do_rd(6, 3'd5, 0, "R5 ext off");
    ext = 1; len = 2; do_wr(10, 3'd5, 0, pat(9));
    len = 0; do_wr(10, 3'd4, 0, pat(10)); do_rd(10, 3'd5, 0, "R5 len zero");
    len = 3; do_wr(11, 3'd5, 0, pat(11)); do_rd(11, 3'd5, 0, "R5 len clamp");
    // R6: upper-half writes
    len = 2; do_wr(7, 3'd5, 0, pat(12));
    do_wr(7, 3'd0, 1, pat(13)); do_rd(7, 3'd5, 0, "R6 part1 clears to length");
    do_wr(8, 3'd5, 0, pat(14));
    len = 1; do_wr(8, 3'd3, 1, pat(15)); do_rd(8, 3'd5, 0, "R6 part1 keeps above length");
    clr = 1; do_wr(8, 3'd3, 1, pat(16)); do_rd(8, 3'd5, 0, "R6 part1 policy clear");
    clr = 0;
    // R7 / R8: read slices
    for (int s = 0; s < 5; s++) do_rd(8, 3'(s), 0, "R7 low slice");
    do_rd(8, 3'd3, 1, "R8 upper half"); do_rd(3, 3'd0, 1, "R8 upper half");
    // R9: same-edge read and write
    wv = 1; widx = 8; wsz = 3'd5; wpt = 0; wdat = pat(17);
    rqv = 1; ridx = 8; rsz = 3'd5; rpt = 0; rtag = "R9 old value";
    step(); wv = 0; rqv = 0;
    do_rd(8, 3'd5, 0, "R9 new value");
    // R10: back-pressure
    rqv = 1; ridx = 3; rsz = 3'd5; rpt = 0; rrdy = 0; rtag = "R10 held";
    step(); ridx = 7; rtag = "R10 after stall";
    repeat (4) step();
    rrdy = 1; step(); step(); rqv = 0; step();
    // mixed traffic
    for (int n = 0; n < 1500; n++) begin
      ext = 1'($urandom); len = LW'($urandom); clr = ($urandom % 4) == 0;
      wv = 1'($urandom); widx = 5'($urandom); wsz = 3'($urandom); wpt = 1'($urandom);
      for (int k = 0; k < VW / 32; k++) wdat[k*32 +: 32] = $urandom;
      rqv = 1'($urandom); ridx = 5'($urandom); rsz = 3'($urandom); rpt = 1'($urandom);
      rrdy = ($urandom % 3) != 0;
      rtag = rpt ? "R8 mixed" : "R7 mixed";
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule